// File: doc/BRIEF.md
# Condition code register unit

This block holds an 8-bit processor status register and the logic that updates it. Two kinds of operation update it. First, arithmetic results: the ALU supplies its operands, its result, an operation code and a size select for byte or word add, add-with-extend, subtract, subtract-with-extend, compare and negate. The block then works out the half-carry, negative, zero, overflow and carry flags itself. Second, software: the instruction decoder can load the whole register, AND, OR or XOR it with an 8-bit immediate in one cycle, or read it at any time through the read port.

The register carries an interrupt mask bit and a user bit. The user bit can act as a second mask. The block gates the maskable interrupt request with the mask bit and always passes the non-maskable request. When the user bit is set up as a mask, the block also reports that a second priority class is masked. The exception sequencer raises an entry strobe, which forces the mask bit on. That strobe wins over any other write in the same cycle.

Top module: `ccr_unit`

## Requirements
- R1: After reset the register reads 0x80: bit 7 (mask) is 1 and all other bits are 0.
- R2: Bit layout: 7 mask, 6 user/second mask, 5 half-carry, 4 user, 3 N, 2 Z, 1 V, 0 C. A byte add (alu_op 0) or add-with-extend (alu_op 1, which includes C as carry-in in the result) with alu_word 0 sets H to the carry out of bit 3. N takes result bit 7, and Z is 1 when result bits 7..0 are all zero. V is set on signed overflow and C on carry out of bit 7.
- R3: A byte subtract (alu_op 2), subtract-with-extend (alu_op 3), compare (alu_op 4) or negate (alu_op 5, result = 0 - alu_a) sets H to the borrow out of bit 3 and C to the borrow out of bit 7. N, Z and V follow the same rules as in R2, with V being signed overflow of the subtraction.
- R4: With alu_word 1 the same operations work on 16 bits. H is the carry or borrow out of bit 11, C the one out of bit 15, N is bit 15, and Z tests all 16 result bits.
- R5: An arithmetic update changes only bits 5 and 3..0. Bits 7, 6 and 4 keep their values.
- R6: A software load (sw_op 1) replaces all 8 bits with sw_data. rd_data always shows the current register. Every register update is visible on rd_data one clock after the strobe is sampled.
- R7: Immediate AND (sw_op 2), OR (sw_op 3) and XOR (sw_op 4) combine sw_data bitwise with all 8 bits in one cycle.
- R8: A software write takes priority over an arithmetic update in the same cycle. The arithmetic update is then dropped.
- R9: exc_entry sets bit 7 and leaves the other bits unchanged. A software write or arithmetic update in the same cycle is discarded.
- R10: irq_take equals irq_req when bit 7 is 0 and is 0 when bit 7 is 1. nmi_take always equals nmi_req.
- R11: With the user bit set up as a mask, class2_masked follows bit 6.
- R12: With no strobe (alu_valid 0, sw_op 0 or an unused code 5..7, exc_entry 0) the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_valid | input | 1 | Arithmetic flag update strobe |
| alu_op | input | 3 | Operation: 0 add, 1 add-extend, 2 sub, 3 sub-extend, 4 compare, 5 negate |
| alu_word | input | 1 | Operand size: 0 byte, 1 word |
| alu_a | input | 16 | First operand (the negated operand for negate) |
| alu_b | input | 16 | Second operand |
| alu_res | input | 16 | ALU result |
| sw_op | input | 3 | Software op: 0 none, 1 load, 2 AND, 3 OR, 4 XOR |
| sw_data | input | 8 | Load value or immediate |
| exc_entry | input | 1 | Exception entry strobe |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| rd_data | output | 8 | Current register value |
| irq_take | output | 1 | Maskable request allowed through |
| nmi_take | output | 1 | Non-maskable request passed through |
| class2_masked | output | 1 | Second priority class masked |

## Verification
Every register change (flags, software writes, exception entry) is due on rd_data one clock after the edge that samples the strobe. The three interrupt outputs are combinational from the current request and the register. The driver applies each stimulus on a falling edge and queues the expected register and interrupt outputs. The monitor pops one entry 2 ns after the next rising edge, so it compares against the updated register together with the request inputs still driven. Expected flags come from wide integer sums in the bench, not from the carry formulas in the design.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    localparam int CCR_W  = 8;
    localparam int BIT_I  = 7;
    localparam int BIT_UI = 6;
    localparam int BIT_H  = 5;
    localparam int BIT_U  = 4;
    localparam int BIT_N  = 3;
    localparam int BIT_Z  = 2;
    localparam int BIT_V  = 1;
    localparam int BIT_C  = 0;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDX = 3'd1,
        OP_SUB  = 3'd2,
        OP_SUBX = 3'd3,
        OP_CMP  = 3'd4,
        OP_NEG  = 3'd5
    } alu_op_e;

    typedef enum logic [2:0] {
        SW_NONE = 3'd0,
        SW_LOAD = 3'd1,
        SW_AND  = 3'd2,
        SW_OR   = 3'd3,
        SW_XOR  = 3'd4
    } sw_op_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } arith_flags_t;

    typedef struct packed {
        logic [CCR_W-1:0] ccr;
    } ccr_state_t;
endpackage

// File: rtl/ccr_size_flags.sv
module ccr_size_flags
    import ccr_pkg::*;
#(
    parameter int W  = 8,
    parameter int HB = 3
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] r,
    input  logic         is_sub,
    output arith_flags_t fl
);
    logic [W-1:0] cy_add;
    logic [W-1:0] cy_sub;
    logic [W-1:0] cy;
    logic         v_add;
    logic         v_sub;

    always_comb begin
        cy_add = (a & b) | ((a | b) & ~r);
        cy_sub = (~a & b) | ((~a | b) & r);
        cy     = is_sub ? cy_sub : cy_add;
        v_add  = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
        v_sub  = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
        fl.h   = cy[HB];
        fl.c   = cy[W-1];
        fl.n   = r[W-1];
        fl.z   = (r == '0);
        fl.v   = is_sub ? v_sub : v_add;
    end
endmodule

// File: rtl/ccr_arith_flags.sv
module ccr_arith_flags
    import ccr_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [2:0]        op,
    input  logic              word,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [WORD_W-1:0] r,
    output logic              op_ok,
    output arith_flags_t      fl
);
    localparam int NSIZE = 2;

    logic              is_sub;
    logic              is_neg;
    logic [WORD_W-1:0] a_eff;
    logic [WORD_W-1:0] b_eff;
    arith_flags_t      fl_sz [NSIZE];

    always_comb begin
        is_neg = (op == OP_NEG);
        is_sub = (op == OP_SUB) || (op == OP_SUBX) || (op == OP_CMP) || is_neg;
        op_ok  = (op <= OP_NEG);
        a_eff  = is_neg ? '0 : a;
        b_eff  = is_neg ? a : b;
    end

    for (genvar g = 0; g < NSIZE; g++) begin : g_size
        localparam int SW = (g == 0) ? BYTE_W : WORD_W;
        localparam int SH = SW - 5;
        ccr_size_flags #(.W(SW), .HB(SH)) u_sz (
            .a      (a_eff[SW-1:0]),
            .b      (b_eff[SW-1:0]),
            .r      (r[SW-1:0]),
            .is_sub (is_sub),
            .fl     (fl_sz[g])
        );
    end

    assign fl = word ? fl_sz[1] : fl_sz[0];
endmodule

// File: rtl/ccr_sw_logic.sv
module ccr_sw_logic
    import ccr_pkg::*;
(
    input  logic [CCR_W-1:0] cur,
    input  logic [2:0]       op,
    input  logic [CCR_W-1:0] data,
    output logic             wr,
    output logic [CCR_W-1:0] nxt
);
    always_comb begin
        wr  = 1'b1;
        nxt = cur;
        case (op)
            SW_LOAD: nxt = data;
            SW_AND:  nxt = cur & data;
            SW_OR:   nxt = cur | data;
            SW_XOR:  nxt = cur ^ data;
            default: wr  = 1'b0;
        endcase
    end
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
    import ccr_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int BYTE_W     = 8,
    parameter bit UI_AS_MASK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_valid,
    input  logic [2:0]        alu_op,
    input  logic              alu_word,
    input  logic [WORD_W-1:0] alu_a,
    input  logic [WORD_W-1:0] alu_b,
    input  logic [WORD_W-1:0] alu_res,
    input  logic [2:0]        sw_op,
    input  logic [CCR_W-1:0]  sw_data,
    input  logic              exc_entry,
    input  logic              irq_req,
    input  logic              nmi_req,
    output logic [CCR_W-1:0]  rd_data,
    output logic              irq_take,
    output logic              nmi_take,
    output logic              class2_masked
);
    localparam logic [CCR_W-1:0] RESET_VAL = CCR_W'(1) << BIT_I;

    ccr_state_t       st_d, st_q;
    arith_flags_t     afl;
    logic             a_ok;
    logic             sw_wr;
    logic [CCR_W-1:0] sw_nxt;

    ccr_arith_flags #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_arith (
        .op    (alu_op),
        .word  (alu_word),
        .a     (alu_a),
        .b     (alu_b),
        .r     (alu_res),
        .op_ok (a_ok),
        .fl    (afl)
    );

    ccr_sw_logic u_sw (
        .cur  (st_q.ccr),
        .op   (sw_op),
        .data (sw_data),
        .wr   (sw_wr),
        .nxt  (sw_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (exc_entry) begin
            st_d.ccr[BIT_I] = 1'b1;
        end else if (sw_wr) begin
            st_d.ccr = sw_nxt;
        end else if (alu_valid && a_ok) begin
            st_d.ccr[BIT_H] = afl.h;
            st_d.ccr[BIT_N] = afl.n;
            st_d.ccr[BIT_Z] = afl.z;
            st_d.ccr[BIT_V] = afl.v;
            st_d.ccr[BIT_C] = afl.c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ccr <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.ccr;
    assign irq_take = irq_req & ~st_q.ccr[BIT_I];
    assign nmi_take = nmi_req;

    if (UI_AS_MASK) begin : g_ui_mask
        assign class2_masked = st_q.ccr[BIT_UI];
    end else begin : g_ui_plain
        assign class2_masked = 1'b0;
    end
endmodule

// File: rtl/ccr_unit_chk.sv
module ccr_unit_chk #(
    parameter bit UI_AS_MASK = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       alu_valid,
    input logic [2:0] sw_op,
    input logic [7:0] sw_data,
    input logic       exc_entry,
    input logic       irq_req,
    input logic       nmi_req,
    input logic [7:0] rd_data,
    input logic       irq_take,
    input logic       nmi_take,
    input logic       class2_masked
);
    logic sw_any;
    assign sw_any = (sw_op >= 3'd1) && (sw_op <= 3'd4);

    AST_EXC_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> rd_data[7]); // R9

    AST_EXC_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> (rd_data[6:0] == $past(rd_data[6:0]))); // R9

    AST_LOAD_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_entry && sw_op == 3'd1) |=> (rd_data == $past(sw_data))); // R6

    AST_ALU_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && !exc_entry && !sw_any) |=>
        (rd_data[7:6] == $past(rd_data[7:6]) && rd_data[4] == $past(rd_data[4]))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_valid && !exc_entry && !sw_any) |=> $stable(rd_data)); // R12

    AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] |-> !irq_take); // R10

    AST_NMI_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> nmi_take); // R10

    AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> irq_req); // R10

    if (UI_AS_MASK) begin : g_c2
        AST_CLASS2_FROM_UI: assert property (@(posedge clk) disable iff (!rst_n)
            class2_masked |-> rd_data[6]); // R11
    end
endmodule

bind ccr_unit ccr_unit_chk #(.UI_AS_MASK(UI_AS_MASK)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alu_valid     (alu_valid),
    .sw_op         (sw_op),
    .sw_data       (sw_data),
    .exc_entry     (exc_entry),
    .irq_req       (irq_req),
    .nmi_req       (nmi_req),
    .rd_data       (rd_data),
    .irq_take      (irq_take),
    .nmi_take      (nmi_take),
    .class2_masked (class2_masked)
);

// File: tb/sim_ccr_unit.sv
`timescale 1ns/1ps
module sim_ccr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alu_valid = 1'b0;
    logic [2:0]  alu_op = 3'd0;
    logic        alu_word = 1'b0;
    logic [15:0] alu_a = '0, alu_b = '0, alu_res = '0;
    logic [2:0]  sw_op = 3'd0;
    logic [7:0]  sw_data = '0;
    logic        exc_entry = 1'b0, irq_req = 1'b0, nmi_req = 1'b0;
    logic [7:0]  rd_data;
    logic        irq_take, nmi_take, class2_masked;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] ccr;
        bit         irq;
        bit         nmi;
        bit         c2;
        string      tag;
    } exp_t;
    exp_t q[$];
    logic [7:0] m;

    always #4 clk = ~clk;

    ccr_unit u0 (
        .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_op(alu_op),
        .alu_word(alu_word), .alu_a(alu_a), .alu_b(alu_b), .alu_res(alu_res),
        .sw_op(sw_op), .sw_data(sw_data), .exc_entry(exc_entry),
        .irq_req(irq_req), .nmi_req(nmi_req), .rd_data(rd_data),
        .irq_take(irq_take), .nmi_take(nmi_take), .class2_masked(class2_masked)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference arithmetic from wide integer sums
    task automatic model(input logic [7:0] cur, input int op, input bit word,
                         input int a_in, input int b_in,
                         output int res, output logic [7:0] nxt);
        int w, mask, nm, half, a, b, cin, full, hs, sa, sb, sv;
        bit h, c, v, sub;
        w    = word ? 16 : 8;
        mask = (1 << w) - 1;
        nm   = (1 << (w - 4)) - 1;
        half = 1 << (w - 1);
        a    = a_in & mask;
        b    = b_in & mask;
        cin  = (op == 1 || op == 3) ? int'(cur[0]) : 0;
        if (op == 5) begin
            b = a;
            a = 0;
        end
        sub = (op >= 2);
        sa  = (a >= half) ? a - (1 << w) : a;
        sb  = (b >= half) ? b - (1 << w) : b;
        if (!sub) begin
            full = a + b + cin;
            hs   = (a & nm) + (b & nm) + cin;
            h    = (hs > nm);
            c    = (full > mask);
            sv   = sa + sb + cin;
        end else begin
            full = a - b - cin;
            hs   = (a & nm) - (b & nm) - cin;
            h    = (hs < 0);
            c    = (full < 0);
            sv   = sa - sb - cin;
        end
        v   = (sv >= half) || (sv < -half);
        res = full & mask;
        nxt = cur;
        nxt[5] = h;
        nxt[3] = ((res >> (w - 1)) & 1) != 0;
        nxt[2] = (res == 0);
        nxt[1] = v;
        nxt[0] = c;
    endtask

    task automatic step(input bit av, input int op, input bit word, input int a,
                        input int b, input int swo, input int swd, input bit exc,
                        input bit irq, input bit nmi, input string tag);
        int res;
        logic [7:0] an;
        exp_t e;
        model(m, op, word, a, b, res, an);
        @(negedge clk);
        alu_valid = av;
        alu_op    = 3'(op);
        alu_word  = word;
        alu_a     = 16'(a);
        alu_b     = 16'(b);
        alu_res   = 16'(res);
        sw_op     = 3'(swo);
        sw_data   = 8'(swd);
        exc_entry = exc;
        irq_req   = irq;
        nmi_req   = nmi;
        if (exc) m[7] = 1'b1;
        else if (swo == 1) m = 8'(swd);
        else if (swo == 2) m = m & 8'(swd);
        else if (swo == 3) m = m | 8'(swd);
        else if (swo == 4) m = m ^ 8'(swd);
        else if (av && op <= 5) m = an;
        e.ccr = m;
        e.irq = irq && !m[7];
        e.nmi = nmi;
        e.c2  = m[6];
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic alu(input int op, input bit word, input int a, input int b, input string tag);
        step(1, op, word, a, b, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic swr(input int swo, input int d, input string tag);
        step(0, 0, 0, 0, 0, swo, d, 0, 0, 0, tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // Monitor: results are due one edge after the strobe
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(rd_data === e.ccr, e.tag, int'(rd_data), int'(e.ccr));
                chk(irq_take === e.irq, {e.tag, " irq R10"}, int'(irq_take), int'(e.irq));
                chk(nmi_take === e.nmi, {e.tag, " nmi R10"}, int'(nmi_take), int'(e.nmi));
                chk(class2_masked === e.c2, {e.tag, " class2 R11"}, int'(class2_masked), int'(e.c2));
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(rd_data === 8'h80, "R1 reset value", int'(rd_data), 8'h80);

        // Clear mask so the flag checks start from zero
        swr(1, 8'h00, "R6 load zero");
        alu(0, 0, 8'h0F, 8'h01, "R2 byte add half carry");
        alu(0, 0, 8'h7F, 8'h01, "R2 byte add overflow");
        alu(0, 0, 8'hFF, 8'h01, "R2 byte add zero carry");
        alu(1, 0, 8'h10, 8'h0F, "R2 byte addx with C");
        alu(2, 0, 8'h10, 8'h01, "R3 byte sub half borrow");
        alu(4, 0, 8'h05, 8'h05, "R3 byte compare equal");
        alu(2, 0, 8'h00, 8'h01, "R3 byte sub borrow");
        alu(3, 0, 8'h00, 8'h00, "R3 byte subx with C");
        alu(5, 0, 8'h80, 0,     "R3 byte negate 0x80");
        alu(5, 0, 8'h00, 0,     "R3 byte negate zero");
        alu(2, 0, 8'h80, 8'h01, "R3 byte sub overflow");
        alu(0, 1, 16'h0F00, 16'h0100, "R4 word add half carry bit 11");
        alu(0, 1, 16'h000F, 16'h0001, "R4 word add no bit 11 carry");
        alu(0, 1, 16'h7FFF, 16'h0001, "R4 word add overflow");
        alu(0, 1, 16'hFFFF, 16'h0001, "R4 word add zero carry");
        alu(2, 1, 16'h1000, 16'h0001, "R4 word sub borrow bit 11");
        alu(5, 1, 16'h8000, 0, "R4 word negate");
        alu(0, 0, 16'h1200, 16'h0000, "R2 byte zero uses low byte");

        swr(1, 8'h50, "R6 load user bits");
        alu(0, 0, 8'hFF, 8'h01, "R5 alu keeps bits 7 6 4");
        swr(1, 8'hD5, "R6 load with mask");
        alu(2, 0, 8'h00, 8'h01, "R5 alu keeps mask");

        swr(2, 8'h3C, "R7 and immediate");
        swr(3, 8'h81, "R7 or immediate");
        swr(4, 8'hFF, "R7 xor immediate");
        step(1, 0, 0, 8'hFF, 8'h01, 1, 8'h22, 0, 0, 0, "R8 sw load beats alu");
        step(1, 0, 0, 8'hFF, 8'h01, 3, 8'h40, 0, 0, 0, "R8 sw or beats alu");

        swr(1, 8'h00, "R6 clear");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R10 irq allowed mask 0");
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, 1, "R9 exception sets mask");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R10 irq blocked nmi passes");
        swr(1, 8'h05, "R6 load");
        step(0, 0, 0, 0, 0, 1, 8'h7F, 1, 0, 0, "R9 exception beats load");
        step(1, 0, 0, 8'hFF, 8'h01, 0, 0, 1, 0, 0, "R9 exception beats alu");
        swr(1, 8'h40, "R11 ui set");
        swr(1, 8'h00, "R11 ui clear");
        step(0, 0, 0, 0, 0, 6, 8'hFF, 0, 0, 0, "R12 unused sw code holds");
        step(1, 7, 0, 8'hFF, 8'h01, 0, 0, 0, 0, 0, "R12 unused alu code holds");
        idle("R12 idle hold");
        idle("R12 idle hold 2");

        for (int i = 0; i < 400; i++) begin
            int kind;
            kind = $urandom_range(0, 9);
            if (kind < 6)
                alu($urandom_range(0, 5), 1'($urandom_range(0, 1)), int'($urandom_range(0, 65535)),
                    int'($urandom_range(0, 65535)), "R2 R3 R4 random alu");
            else if (kind < 8)
                step(1, $urandom_range(0, 5), 0, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                     $urandom_range(0, 4), int'($urandom_range(0, 255)), 0,
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R7 R8 random sw");
            else if (kind < 9)
                step(0, 0, 0, 0, 0, 0, 0, 1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R9 random exc");
            else
                step(0, 0, 0, 0, 0, 0, 0, 0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R12 random idle");
        end
        idle("R12 final idle");
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule